// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address for a burst-capable synchronous memory. A load command captures a starting address from outside. Each later advance command steps the two least significant address bits to the next beat of a four-beat burst. The bits above them never change during a burst. A mode pin picks the beat order. Linear order counts upward and wraps modulo four. Interleaved order XORs the starting low bits with the beat index.

A single shared control pin chooses between loading and advancing. A select pin terminates the burst when it is low during a load-type command. A clock enable freezes all state. The block has no data path, so it has no valid/ready stream. All pins are plain control and status pins, and the block applies no back-pressure. The current word address and a burst-active flag come straight from the registers through a small combinational reorder stage.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no command applied, `word_addr` is 0 and `burst_on` is 0.
- R2: When `clk_en`=1, `ld_adv`=0 and `sel`=1 at a rising edge, the next cycle shows `word_addr` equal to the `ext_addr` sampled at that edge, and `burst_on`=1 (beat index 0).
- R3: With `ilv_mode`=0 (linear), beat k of a burst drives `word_addr[1:0]` = (start[1:0] + k) mod 4.
- R4: With `ilv_mode`=1 (interleaved), beat k of a burst drives `word_addr[1:0]` = start[1:0] XOR k. The mode pin acts combinationally on the current output.
- R5: An advance taken at the fourth beat (k=3) returns to beat 0, the starting address. Bits above bit 1 of `word_addr` change only on a load.
- R6: When `clk_en`=0, every other input is ignored, and `word_addr` (for a fixed mode) and `burst_on` keep their values.
- R7: When `clk_en`=1, `ld_adv`=0 and `sel`=0, `burst_on` clears on the next cycle and `word_addr` holds.
- R8: An advance (`clk_en`=1, `ld_adv`=1) while `burst_on`=0 leaves `word_addr` and `burst_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable, 1 = accept commands |
| ld_adv | input | 1 | 0 = load (or stop if deselected), 1 = advance |
| sel | input | 1 | Combined chip select, 1 = selected |
| ilv_mode | input | 1 | Beat order, 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W | External starting address |
| word_addr | output | ADDR_W | Current word address |
| burst_on | output | 1 | Burst in progress |

## Verification
The in-module assertions check the following on every cycle:
- A load captures the address and opens a burst at beat 0.
- An advance increments the beat and wraps from the last beat to beat 0.
- The upper address bits stay frozen outside loads.
- The clock enable freezes the state.
- A deselect closes the burst.
- An idle advance changes nothing.

The per-mode beat orderings are shown only by the bench scenarios, whose expected addresses are computed independently. Those scenarios include a start address with all upper bits set, which shows that wrapping never carries. A mode switch in the middle of a burst and long random command mixes are likewise covered only by the bench.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2,
    CMD_STOP = 2'd3
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic en, input logic adv,
                                      input logic sel, input logic active);
    if (!en)       return CMD_NONE;
    else if (!adv) return sel ? CMD_LOAD : CMD_STOP;
    else if (active) return CMD_STEP;
    else           return CMD_NONE;
  endfunction

endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ld_adv,
  input  logic              sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] base,
  output logic              active
);

  assign cmd = decode_cmd(clk_en, ld_adv, sel, active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      active <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          base   <= ext_addr;
          active <= 1'b1;
        end
        CMD_STOP: active <= 1'b0;
        default:  ;
      endcase
    end
  end

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ld_adv && sel) |=> (active && base == $past(ext_addr)));

  a_r6_enable_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(base) && $stable(active)));

  a_r7_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ld_adv && !sel) |=> (!active && $stable(base)));

  a_r8_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ld_adv && !active) |=> (!active && $stable(base)));

endmodule

// File: rtl/bag_beat.sv
module bag_beat
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)               beat <= '0;
    else if (cmd == CMD_LOAD) beat <= '0;
    else if (cmd == CMD_STEP) beat <= beat + 1'b1;
  end

  a_r2_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (beat == '0));

  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP && beat != LAST) |=> (beat == BEAT_W'($past(beat) + 1'b1)));

  a_r5_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP && beat == LAST) |=> (beat == '0));

  a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NONE || cmd == CMD_STOP) |=> $stable(beat));

endmodule

// File: rtl/bag_order.sv
module bag_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_low[i] = start[i] ^ beat[i];
  end

  assign low = ilv ? xor_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ld_adv,
  input  logic              sel,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_on
);

  cmd_e              cmd;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  bag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ld_adv(ld_adv),
    .sel(sel), .ext_addr(ext_addr), .cmd(cmd), .base(base), .active(burst_on)
  );

  bag_beat #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .beat(beat)
  );

  bag_order #(.BEAT_W(BEAT_W)) u_order (
    .start(base[BEAT_W-1:0]), .beat(beat), .ilv(ilv_mode), .low(low)
  );

  assign word_addr = {base[ADDR_W-1:BEAT_W], low};

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && !ld_adv && sel) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

  a_r2_load_address: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ld_adv && sel) |=> (word_addr == $past(ext_addr)));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          ld_adv = 1'b1;
  logic          sel = 1'b0;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] word_addr;
  logic          burst_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_on = 1'b0;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ld_adv(ld_adv), .sel(sel),
    .ilv_mode(ilv_mode), .ext_addr(ext_addr), .word_addr(word_addr),
    .burst_on(burst_on)
  );

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] a_exp, logic on_exp);
    n_chk++;
    if (word_addr !== a_exp || burst_on !== on_exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h on=%b expected addr=%h on=%b",
               req, word_addr, burst_on, a_exp, on_exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Drive one cycle of inputs (called at a falling edge), update the model,
  // and compare after the rising edge.
  task automatic cycle(logic en, logic adv, logic s, logic m, logic [AW-1:0] a);
    string tag;
    clk_en = en; ld_adv = adv; sel = s; ilv_mode = m; ext_addr = a;
    @(posedge clk);
    if (!en)                 tag = "R6";
    else if (!adv)           tag = s ? "R2" : "R7";
    else if (!m_on)          tag = "R8";
    else if (m_beat == 2'd3) tag = "R5";
    else                     tag = m ? "R4" : "R3";
    if (en) begin
      if (!adv && s) begin
        m_base = a; m_beat = 2'd0; m_on = 1'b1;
      end else if (!adv) begin
        m_on = 1'b0;
      end else if (m_on) begin
        m_beat = m_beat + 2'd1;
      end
    end
    #2;
    check(tag, exp_addr(m_base, m_beat, m), m_on);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    cycle(1'b0, 1'b1, 1'b1, 1'b0, '0);
    check("R1", '0, 1'b0);

    // R8: advance with no burst open
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 17'h00005);

    // R3, R5: linear burst from low bits 3, all upper bits set (no carry)
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 17'h1FFFF);
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0, '0);
    n_chk++;
    if (word_addr !== 17'h1FFFC) begin
      n_bad++;
      $display("FAIL R3: addr=%h expected addr=%h", word_addr, 17'h1FFFC);
    end

    // R4, R5: interleaved burst from low bits 2
    cycle(1'b1, 1'b0, 1'b1, 1'b1, 17'h0ABCE);
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, '0);
    n_chk++;
    if (word_addr !== 17'h0ABCF) begin
      n_bad++;
      $display("FAIL R4: addr=%h expected addr=%h", word_addr, 17'h0ABCF);
    end

    // R4: mode switch mid-burst reorders the present output at once
    cycle(1'b1, 1'b1, 1'b1, 1'b0, '0);

    // R6: clock enable low ignores load, stop and advance
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h12345);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 17'h00000);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 17'h00000);

    // R7 then R8: stop, then an advance has no effect
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 17'h1AAAA);
    cycle(1'b1, 1'b1, 1'b1, 1'b0, '0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);

    // Constrained random mix
    m = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) m = ~m;
      cycle(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
            m, AW'($urandom));
    end

    finish_run();
  end

endmodule